// File: doc/BRIEF.md
# Word-to-Byte FIFO Pair with Threshold Flags

This block holds the data staged between a 32-bit register port and a serial shift engine. In the transmit direction the register side pushes whole words, and the shifter drains them one byte at a time. In the receive direction the shifter deposits bytes one at a time, and the register side collects them as whole words. Within each word the lowest byte lane (bits 7:0) is the first byte on the serial side.

Each direction has level flags (full, empty) and a ready flag. The ready flag compares the free space, for transmit, or the held bytes, for receive, against a 3-bit threshold set by the user. There are also sticky error flags for overflow and underflow. A flush request empties both FIFOs and clears the sticky flags. The busy indication clears itself one cycle later. A synchronous soft reset clears the same state in the cycle it is applied. Software normally sets the receive threshold to the word byte count minus one and the transmit threshold to seven minus the byte count.

Top module: `spi_byte_fifo_pair`

## Requirements
- R1: After rst_n is released: tx_empty=1, rx_empty=1, tx_full=0, rx_full=0, all four sticky flags are 0, flush_busy=0 and rd_word=0.
- R2: A word pushed with wr_push leaves the transmit side byte by byte, starting with bits 7:0, then 15:8, 23:16 and 31:24. tx_byte always shows the oldest held byte, and each tx_byte_pop moves on to the next one.
- R3: Four bytes pushed with rx_byte_push are popped with rd_pop as one word, with the first byte in bits 7:0. rd_word is a register that updates at the clock edge that samples rd_pop.
- R4: tx_empty is 1 exactly when the transmit FIFO holds no bytes. tx_full is 1 exactly when fewer than 4 of its 8 byte slots are free.
- R5: rx_full is 1 exactly when all 8 receive bytes are held. rx_empty is 1 exactly when fewer than 4 bytes (less than one word) are held.
- R6: tx_ready is 1 exactly when the number of free transmit bytes is strictly greater than wr_thr (3 bits, unsigned).
- R7: rx_ready is 1 exactly when the number of held receive bytes is strictly greater than rd_thr (3 bits, unsigned).
- R8: A wr_push while tx_full=1 drops the word and leaves the held bytes unchanged. It sets tx_ovf, which then stays at 1.
- R9: A rd_pop while rx_empty=1 loads rd_word with 0, leaves the held bytes unchanged and sets rx_unf, which then stays at 1.
- R10: A tx_byte_pop while tx_empty=1 sets tx_unf. An rx_byte_push while rx_full=1 drops the byte and sets rx_ovf. Both flags are sticky.
- R11: A flush_req pulse makes flush_busy 1 for exactly one cycle, starting after the next edge. At the end of that cycle both FIFOs are empty and all sticky flags are 0. Pushes and pops presented during the busy cycle are ignored.
- R12: soft_rst empties both FIFOs and clears the sticky flags, flush_busy and rd_word at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of contents and flags |
| wr_thr | input | 3 | Transmit ready threshold (free bytes) |
| rd_thr | input | 3 | Receive ready threshold (held bytes) |
| flush_req | input | 1 | Request to flush both FIFOs |
| flush_busy | output | 1 | Flush in progress, clears itself |
| wr_push | input | 1 | Push wr_word into the transmit FIFO |
| wr_word | input | 32 | Word from the register side |
| tx_full | output | 1 | Transmit FIFO cannot take a word |
| tx_empty | output | 1 | Transmit FIFO holds no bytes |
| tx_ready | output | 1 | Free transmit bytes above wr_thr |
| tx_ovf | output | 1 | Sticky: a word was dropped |
| tx_unf | output | 1 | Sticky: a byte pop found it empty |
| tx_byte | output | 8 | Oldest transmit byte (0 when empty) |
| tx_byte_pop | input | 1 | Shifter takes tx_byte |
| rx_byte | input | 8 | Byte from the shifter |
| rx_byte_push | input | 1 | Push rx_byte into the receive FIFO |
| rd_pop | input | 1 | Pop one word from the receive FIFO |
| rd_word | output | 32 | Last popped word (0 after an underflow) |
| rx_full | output | 1 | Receive FIFO holds 8 bytes |
| rx_empty | output | 1 | Receive FIFO holds less than a word |
| rx_ready | output | 1 | Held receive bytes above rd_thr |
| rx_ovf | output | 1 | Sticky: a byte was dropped |
| rx_unf | output | 1 | Sticky: a word pop found it empty |

## Verification
The level and ready flags and tx_byte are decoded by logic from stored state. Each is therefore due in the cycle after the edge that captured a push or pop. rd_word and the sticky flags update at that same edge, and a flush is seen as one busy cycle after the first edge, with the cleared state after the second. The bench changes inputs on the falling edge and samples on the next falling edge, so every result is read exactly one edge after its stimulus. Threshold changes touch only the decoding logic, so the bench checks them a nanosecond after applying them and never across an edge.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int BYTE_W = 8;

    // Which side of a ring moves whole words
    typedef enum logic {
        SIDE_WORD_IN  = 1'b0,   // words in, bytes out (transmit)
        SIDE_BYTE_IN  = 1'b1    // bytes in, words out (receive)
    } ring_side_e;

    typedef struct packed {
        logic tx_ovf;
        logic tx_unf;
        logic rx_ovf;
        logic rx_unf;
    } err_flags_t;

endpackage

// File: rtl/spi_fifo_ring.sv
module spi_fifo_ring
    import spi_fifo_pkg::*;
#(
    parameter int         DEPTH      = 8,
    parameter int         WORD_BYTES = 4,
    parameter ring_side_e SIDE       = SIDE_WORD_IN,
    localparam int        PTR_W      = $clog2(DEPTH),
    localparam int        CNT_W      = PTR_W + 1,
    localparam int        PUSH_N     = (SIDE == SIDE_WORD_IN) ? WORD_BYTES : 1,
    localparam int        POP_N      = (SIDE == SIDE_WORD_IN) ? 1 : WORD_BYTES
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic [PUSH_N*BYTE_W-1:0]   push_data,
    input  logic                       pop,
    output logic [POP_N*BYTE_W-1:0]    pop_data,
    output logic [CNT_W-1:0]           level,
    output logic                       push_reject,
    output logic                       pop_reject
);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } ring_t;

    ring_t             ring_d, ring_q;
    logic [CNT_W-1:0]  free_bytes;
    logic              push_ok, pop_ok;
    logic [PTR_W-1:0]  wr_base, wr_idx, rd_idx;

    always_comb begin
        ring_d     = ring_q;
        wr_idx     = '0;
        free_bytes = CNT_W'(DEPTH) - ring_q.cnt;
        push_ok    = push && (free_bytes >= CNT_W'(PUSH_N));
        pop_ok     = pop && (ring_q.cnt >= CNT_W'(POP_N));
        wr_base    = ring_q.rd + ring_q.cnt[PTR_W-1:0];
        if (clear) begin
            ring_d.rd  = '0;
            ring_d.cnt = '0;
        end else begin
            if (push_ok) begin
                for (int i = 0; i < PUSH_N; i++) begin
                    wr_idx = wr_base + PTR_W'(i);
                    ring_d.mem[wr_idx] = push_data[i*BYTE_W +: BYTE_W];
                end
            end
            if (pop_ok) begin
                ring_d.rd = ring_q.rd + PTR_W'(POP_N);
            end
            ring_d.cnt = ring_q.cnt
                       + (push_ok ? CNT_W'(PUSH_N) : '0)
                       - (pop_ok  ? CNT_W'(POP_N)  : '0);
        end
    end

    // Head lanes: oldest byte in the lowest lane, zero when too few are held
    always_comb begin
        pop_data = '0;
        rd_idx   = '0;
        if (ring_q.cnt >= CNT_W'(POP_N)) begin
            for (int i = 0; i < POP_N; i++) begin
                rd_idx = ring_q.rd + PTR_W'(i);
                pop_data[i*BYTE_W +: BYTE_W] = ring_q.mem[rd_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign level       = ring_q.cnt;
    assign push_reject = push && !push_ok && !clear;
    assign pop_reject  = pop && !pop_ok && !clear;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH)); // R5

    AST_REJECT_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_reject && !pop) |=> (level == $past(level))); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level == '0)); // R12

endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
    import spi_fifo_pkg::*;
#(
    parameter int         DEPTH      = 8,
    parameter int         WORD_BYTES = 4,
    parameter int         THR_W      = 3,
    parameter ring_side_e SIDE       = SIDE_WORD_IN,
    localparam int        CNT_W      = $clog2(DEPTH) + 1,
    localparam int        CMP_W      = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1
)(
    input  logic [CNT_W-1:0] level,
    input  logic [THR_W-1:0] thresh,
    output logic             full,
    output logic             empty,
    output logic             ready
);

    generate
        if (SIDE == SIDE_WORD_IN) begin : g_word_in
            logic [CMP_W-1:0] free_x;
            assign free_x = CMP_W'(DEPTH) - CMP_W'(level);
            assign full   = free_x < CMP_W'(WORD_BYTES);
            assign empty  = (level == '0);
            assign ready  = free_x > CMP_W'(thresh);
        end else begin : g_byte_in
            logic [CMP_W-1:0] held_x;
            assign held_x = CMP_W'(level);
            assign full   = (held_x == CMP_W'(DEPTH));
            assign empty  = held_x < CMP_W'(WORD_BYTES);
            assign ready  = held_x > CMP_W'(thresh);
        end
    endgenerate

endmodule

// File: rtl/spi_byte_fifo_pair.sv
module spi_byte_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int  DEPTH      = 8,
    parameter int  WORD_BYTES = 4,
    parameter int  THR_W      = 3,
    localparam int LANE_W     = WORD_BYTES * BYTE_W,
    localparam int CNT_W      = $clog2(DEPTH) + 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [THR_W-1:0]  wr_thr,
    input  logic [THR_W-1:0]  rd_thr,
    input  logic              flush_req,
    output logic              flush_busy,
    input  logic              wr_push,
    input  logic [LANE_W-1:0] wr_word,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_ready,
    output logic              tx_ovf,
    output logic              tx_unf,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_byte_pop,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_byte_push,
    input  logic              rd_pop,
    output logic [LANE_W-1:0] rd_word,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_ready,
    output logic              rx_ovf,
    output logic              rx_unf
);

    typedef struct packed {
        err_flags_t        err;
        logic              flush;
        logic [LANE_W-1:0] word;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              ring_clear;
    logic [CNT_W-1:0]  tx_level, rx_level;
    logic [LANE_W-1:0] rx_head;
    logic              tx_push_rej, tx_pop_rej, rx_push_rej, rx_pop_rej;

    assign ring_clear = soft_rst | ctl_q.flush;

    spi_fifo_ring #(
        .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .SIDE(SIDE_WORD_IN)
    ) u_tx_ring (
        .clk(clk), .rst_n(rst_n), .clear(ring_clear),
        .push(wr_push), .push_data(wr_word),
        .pop(tx_byte_pop), .pop_data(tx_byte),
        .level(tx_level), .push_reject(tx_push_rej), .pop_reject(tx_pop_rej)
    );

    spi_fifo_ring #(
        .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .SIDE(SIDE_BYTE_IN)
    ) u_rx_ring (
        .clk(clk), .rst_n(rst_n), .clear(ring_clear),
        .push(rx_byte_push), .push_data(rx_byte),
        .pop(rd_pop), .pop_data(rx_head),
        .level(rx_level), .push_reject(rx_push_rej), .pop_reject(rx_pop_rej)
    );

    spi_fifo_flags #(
        .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .THR_W(THR_W), .SIDE(SIDE_WORD_IN)
    ) u_tx_flags (
        .level(tx_level), .thresh(wr_thr),
        .full(tx_full), .empty(tx_empty), .ready(tx_ready)
    );

    spi_fifo_flags #(
        .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .THR_W(THR_W), .SIDE(SIDE_BYTE_IN)
    ) u_rx_flags (
        .level(rx_level), .thresh(rd_thr),
        .full(rx_full), .empty(rx_empty), .ready(rx_ready)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (soft_rst) begin
            ctl_d = '0;
        end else if (ctl_q.flush) begin
            ctl_d.err   = '0;
            ctl_d.flush = 1'b0;
        end else begin
            ctl_d.flush       = flush_req;
            ctl_d.err.tx_ovf  = ctl_q.err.tx_ovf | tx_push_rej;
            ctl_d.err.tx_unf  = ctl_q.err.tx_unf | tx_pop_rej;
            ctl_d.err.rx_ovf  = ctl_q.err.rx_ovf | rx_push_rej;
            ctl_d.err.rx_unf  = ctl_q.err.rx_unf | rx_pop_rej;
            if (rd_pop) begin
                ctl_d.word = rx_head;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flush_busy = ctl_q.flush;
    assign rd_word    = ctl_q.word;
    assign tx_ovf     = ctl_q.err.tx_ovf;
    assign tx_unf     = ctl_q.err.tx_unf;
    assign rx_ovf     = ctl_q.err.rx_ovf;
    assign rx_unf     = ctl_q.err.rx_unf;

    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> !flush_busy); // R11

    AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> (tx_empty && rx_level == '0 && !tx_ovf && !rx_unf)); // R11

    AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_push && tx_full && !soft_rst && !flush_busy) |=> tx_ovf); // R8

    AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !soft_rst && !flush_busy) |=> tx_ovf); // R8

    AST_RX_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && rx_empty && !soft_rst && !flush_busy) |=> (rd_word == '0 && rx_unf)); // R9

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_empty && !tx_ovf && !tx_unf && !rx_ovf && !rx_unf
                      && !flush_busy && rd_word == '0)); // R12

endmodule

// File: tb/spi_byte_fifo_pair_bench.sv
module spi_byte_fifo_pair_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [2:0]  wr_thr = 3'd3;
    logic [2:0]  rd_thr = 3'd3;
    logic        flush_req = 1'b0;
    logic        flush_busy;
    logic        wr_push = 1'b0;
    logic [31:0] wr_word = '0;
    logic        tx_full, tx_empty, tx_ready, tx_ovf, tx_unf;
    logic [7:0]  tx_byte;
    logic        tx_byte_pop = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_push = 1'b0;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_word;
    logic        rx_full, rx_empty, rx_ready, rx_ovf, rx_unf;

    int vectors = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    spi_byte_fifo_pair u_spi_byte_fifo_pair (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_thr(wr_thr), .rd_thr(rd_thr),
        .flush_req(flush_req), .flush_busy(flush_busy),
        .wr_push(wr_push), .wr_word(wr_word),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_ready(tx_ready),
        .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .tx_byte(tx_byte), .tx_byte_pop(tx_byte_pop),
        .rx_byte(rx_byte), .rx_byte_push(rx_byte_push),
        .rd_pop(rd_pop), .rd_word(rd_word),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_ready(rx_ready),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clean();
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        wr_push = 1'b1; wr_word = w; step(); wr_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_byte_pop = 1'b1; step(); tx_byte_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_byte_push = 1'b1; rx_byte = b; step(); rx_byte_push = 1'b0;
    endtask

    task automatic pop_word();
        rd_pop = 1'b1; step(); rd_pop = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1", "tx_empty", tx_empty, 1);
        check("R1", "rx_empty", rx_empty, 1);
        check("R1", "tx_full", tx_full, 0);
        check("R1", "rx_full", rx_full, 0);
        check("R1", "sticky", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
        check("R1", "flush_busy", flush_busy, 0);
        check("R1", "rd_word", rd_word, 0);
    endtask

    task automatic t_tx_order();
        clean();
        push_word(32'h44332211);
        check("R4", "tx_empty after push", tx_empty, 0);
        check("R2", "byte 0", tx_byte, 8'h11);
        pop_tx(); check("R2", "byte 1", tx_byte, 8'h22);
        pop_tx(); check("R2", "byte 2", tx_byte, 8'h33);
        pop_tx(); check("R2", "byte 3", tx_byte, 8'h44);
        pop_tx();
        check("R4", "tx_empty after drain", tx_empty, 1);
        check("R10", "no tx_unf yet", tx_unf, 0);
    endtask

    task automatic t_tx_full_ovf();
        logic [7:0] exp_b [8] = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hB0, 8'hB1, 8'hB2, 8'hB3};
        clean();
        wr_thr = 3'd3;
        push_word(32'hA3A2A1A0);
        check("R4", "tx_full one word", tx_full, 0);
        check("R6", "tx_ready free4>3", tx_ready, 1);
        push_word(32'hB3B2B1B0);
        check("R4", "tx_full two words", tx_full, 1);
        check("R6", "tx_ready free0>3", tx_ready, 0);
        check("R8", "tx_ovf before", tx_ovf, 0);
        push_word(32'hC3C2C1C0);
        check("R8", "tx_ovf set", tx_ovf, 1);
        for (int i = 0; i < 8; i++) begin
            check("R8", "kept byte", tx_byte, exp_b[i]);
            pop_tx();
        end
        check("R8", "dropped word absent", tx_empty, 1);
        pop_tx();
        check("R10", "tx_unf set", tx_unf, 1);
        check("R8", "tx_ovf sticky", tx_ovf, 1);
    endtask

    task automatic t_thresholds();
        clean();
        push_word(32'h01020304);
        wr_thr = 3'd4; #1;
        check("R6", "free4 vs thr4", tx_ready, 0);
        wr_thr = 3'd3; #1;
        check("R6", "free4 vs thr3", tx_ready, 1);
        wr_thr = 3'd0; #1;
        check("R6", "free4 vs thr0", tx_ready, 1);
        step();
        push_rx(8'h10);
        push_rx(8'h20);
        rd_thr = 3'd1; #1;
        check("R7", "held2 vs thr1", rx_ready, 1);
        rd_thr = 3'd2; #1;
        check("R7", "held2 vs thr2", rx_ready, 0);
        wr_thr = 3'd3; rd_thr = 3'd3;
        step();
    endtask

    task automatic t_rx_pack();
        clean();
        push_rx(8'hAA); push_rx(8'hBB); push_rx(8'hCC);
        check("R5", "rx_empty held3", rx_empty, 1);
        push_rx(8'hDD);
        check("R5", "rx_empty held4", rx_empty, 0);
        check("R5", "rx_full held4", rx_full, 0);
        push_rx(8'hEE); push_rx(8'hFF); push_rx(8'h01); push_rx(8'h02);
        check("R5", "rx_full held8", rx_full, 1);
        push_rx(8'h99);
        check("R10", "rx_ovf set", rx_ovf, 1);
        pop_word();
        check("R3", "first word", rd_word, 32'hDDCCBBAA);
        pop_word();
        check("R10", "second word without dropped byte", rd_word, 32'h0201FFEE);
        check("R5", "rx_empty drained", rx_empty, 1);
    endtask

    task automatic t_rx_underflow();
        clean();
        push_rx(8'h11); push_rx(8'h22);
        pop_word();
        check("R9", "rd_word zero", rd_word, 0);
        check("R9", "rx_unf set", rx_unf, 1);
        push_rx(8'h33); push_rx(8'h44);
        pop_word();
        check("R9", "held bytes kept", rd_word, 32'h44332211);
        check("R9", "rx_unf sticky", rx_unf, 1);
    endtask

    task automatic t_flush();
        clean();
        push_word(32'h0000AA55);
        push_word(32'h0000BB66);
        push_word(32'h0000CC77);
        push_rx(8'h55);
        pop_word();
        check("R11", "setup tx_ovf", tx_ovf, 1);
        flush_req = 1'b1; step(); flush_req = 1'b0;
        check("R11", "flush_busy on", flush_busy, 1);
        wr_push = 1'b1; wr_word = 32'h12345678; rx_byte_push = 1'b1; rx_byte = 8'h77;
        step();
        wr_push = 1'b0; rx_byte_push = 1'b0;
        check("R11", "flush_busy off", flush_busy, 0);
        check("R11", "tx emptied, push ignored", tx_empty, 1);
        check("R11", "rx emptied", rx_empty, 1);
        check("R11", "sticky cleared", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
        push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
        pop_word();
        check("R11", "rx fully emptied", rd_word, 32'h0);
        push_rx(8'h04);
        pop_word();
        check("R11", "fresh word only", rd_word, 32'h04030201);
    endtask

    task automatic t_soft_reset();
        clean();
        push_word(32'h1);
        push_word(32'h2);
        push_word(32'h3);
        push_rx(8'h0A); push_rx(8'h0B); push_rx(8'h0C); push_rx(8'h0D);
        pop_word();
        push_rx(8'h1A); push_rx(8'h1B); push_rx(8'h1C); push_rx(8'h1D);
        check("R12", "setup rd_word", rd_word, 32'h0D0C0B0A);
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        check("R12", "tx_empty", tx_empty, 1);
        check("R12", "rx_empty", rx_empty, 1);
        check("R12", "tx_ovf", tx_ovf, 0);
        check("R12", "rd_word", rd_word, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_tx_order();
        t_tx_full_ovf();
        t_thresholds();
        t_rx_pack();
        t_rx_underflow();
        t_flush();
        t_soft_reset();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #200000ns;
        if (!finished) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule